// File: doc/BRIEF.md
# First-Fit Queue Memory Page Allocator

This block keeps track of which pages of a shared queue memory are taken. Each page holds sixteen words and the default memory has 128 pages. A client asks for a run of 1, 2, 4 or 8 consecutive pages. The block scans candidate start pages from page 0 upward, one candidate per clock. It claims the first run that is entirely free and reports the start page of that run. If no run fits below the top of the memory, it reports failure. A client can also hand back a run by giving its start page and size. The pages in that run become free again.

The lowest pages hold configuration data and stay taken from reset onward. A search never returns them, and a release never frees them. Requests are accepted only while the block is idle. A `busy` output covers the whole search. A single-cycle `done` pulse carries the result of each request.

Top module: `page_allocator`

## Requirements
- R1: After reset `busy` and `done` are low, and pages 0 to RESV_PAGES-1 (default 4) count as occupied.
- R2: `req_size` is a 2-bit code: 0 means 1 page, 1 means 2 pages, 2 means 4 pages and 3 means 8 pages.
- R3: An allocation returns, in `done_page` with `done_fail` low, the lowest start page s for which pages s to s+len-1 are all free.
- R4: The candidate start moves up by exactly one page per clock, beginning at page 0. A successful allocation at page s pulses `done` s+1 clocks after the edge that accepted the request.
- R5: When no start page s with s+len <= NUM_PAGES has a free run, `done` pulses with `done_fail` high. This happens NUM_PAGES-len+2 clocks after acceptance, and no page changes state.
- R6: The pages granted by a successful allocation stay occupied until they are released, so no later grant overlaps them.
- R7: A release (`req_free`=1) frees exactly pages `req_start` to `req_start`+len-1. `done` pulses on the clock after acceptance with `done_fail` low and `done_page` equal to `req_start`, and `busy` stays low.
- R8: Reserved pages are never granted, and a release that covers them leaves them occupied.
- R9: `busy` is high from acceptance of an allocation until its `done`. A request presented while `busy` is high is ignored.
- R10: `done` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_free | input | 1 | 0 = allocate, 1 = release |
| req_size | input | 2 | Run length code (1, 2, 4 or 8 pages) |
| req_start | input | PW | First page of the run to release |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Allocation found no room |
| done_page | output | PW | Granted start page, or released start page |

## Verification
A corrupted occupancy bit shows up at the ports the next time a search reaches that page. The granted page then comes out lower or higher than the bench's own first-fit model predicts. A candidate counter that skips or stalls shows up at once, because `done` then arrives after a different number of clocks than start+1. A release that frees too much or too little is caught by the next allocation of the same size. The sweeps fill the memory completely, carve holes of known shape into it, and then run a long mixed sequence. Every result and every latency is compared against an arithmetic model.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } pa_state_e;

  // Pages covered by a 2-bit size code.
  function automatic int run_len(input logic [1:0] code);
    return 1 << code;
  endfunction

  // True when page idx lies inside the run [base, base+len).
  function automatic logic covers(input int idx, input int base, input int len);
    return (idx >= base) && (idx < base + len);
  endfunction

endpackage

// File: rtl/page_bitmap.sv
module page_bitmap
  import pa_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int RESV_PAGES = 4,
  parameter int CW         = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [CW-1:0]        set_base,
  input  logic [1:0]           set_code,
  input  logic                 clr_en,
  input  logic [CW-1:0]        clr_base,
  input  logic [1:0]           clr_code,
  output logic [NUM_PAGES-1:0] used
);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    if (g < RESV_PAGES) begin : g_resv
      assign used[g] = 1'b1;
    end else begin : g_free
      logic bit_q;
      logic hit_set, hit_clr;
      assign hit_set = set_en && covers(g, int'(set_base), run_len(set_code));
      assign hit_clr = clr_en && covers(g, int'(clr_base), run_len(clr_code));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bit_q <= 1'b0;
        else if (hit_set) bit_q <= 1'b1;
        else if (hit_clr) bit_q <= 1'b0;
      end
      assign used[g] = bit_q;
    end
  end

endmodule

// File: rtl/window_probe.sv
module window_probe
  import pa_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  parameter int CW        = 8
) (
  input  logic [NUM_PAGES-1:0] used,
  input  logic [CW-1:0]        cand,
  input  logic [1:0]           code,
  output logic                 conflict,
  output logic                 beyond
);

  logic [NUM_PAGES-1:0] hit;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_hit
    assign hit[g] = used[g] && covers(g, int'(cand), run_len(code));
  end

  assign conflict = |hit;
  assign beyond   = (int'(cand) + run_len(code)) > NUM_PAGES;

endmodule

// File: rtl/search_ctrl.sv
module search_ctrl
  import pa_pkg::*;
#(
  parameter int PW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_free,
  input  logic [1:0]    req_size,
  input  logic [PW-1:0] req_start,
  input  logic          conflict,
  input  logic          beyond,
  output logic [CW-1:0] cand,
  output logic [1:0]    cur_code,
  output logic          last_free,
  output logic          busy,
  output logic          ev_hit,
  output logic          ev_miss,
  output logic          ev_free,
  output logic [CW-1:0] clr_base,
  output logic          done,
  output logic          done_fail,
  output logic [PW-1:0] done_page
);

  pa_state_e state;
  logic      accept;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign ev_free  = accept && req_free;
  assign ev_hit   = (state == ST_SEARCH) && !beyond && !conflict;
  assign ev_miss  = (state == ST_SEARCH) && beyond;
  assign busy     = (state == ST_SEARCH);
  assign clr_base = {1'b0, req_start};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cand      <= '0;
      cur_code  <= 2'd0;
      last_free <= 1'b0;
      done      <= 1'b0;
      done_fail <= 1'b0;
      done_page <= '0;
    end else begin
      done      <= ev_hit || ev_miss || ev_free;
      done_fail <= ev_miss;
      if (accept) begin
        cur_code  <= req_size;
        last_free <= req_free;
        cand      <= '0;
        if (!req_free) state <= ST_SEARCH;
        else           done_page <= req_start;
      end else if (state == ST_SEARCH) begin
        if (ev_hit) begin
          state     <= ST_IDLE;
          done_page <= cand[PW-1:0];
        end else if (ev_miss) begin
          state     <= ST_IDLE;
          done_page <= '0;
        end else begin
          cand <= cand + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/page_allocator.sv
module page_allocator
  import pa_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int RESV_PAGES = 4,
  localparam int PW        = $clog2(NUM_PAGES),
  localparam int CW        = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_free,
  input  logic [1:0]    req_size,
  input  logic [PW-1:0] req_start,
  output logic          busy,
  output logic          done,
  output logic          done_fail,
  output logic [PW-1:0] done_page
);

  logic [NUM_PAGES-1:0] used;
  logic [CW-1:0]        cand;
  logic [CW-1:0]        clr_base;
  logic [1:0]           cur_code;
  logic                 last_free;
  logic                 conflict, beyond;
  logic                 ev_hit, ev_miss, ev_free;

  search_ctrl #(.PW(PW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_free  (req_free),
    .req_size  (req_size),
    .req_start (req_start),
    .conflict  (conflict),
    .beyond    (beyond),
    .cand      (cand),
    .cur_code  (cur_code),
    .last_free (last_free),
    .busy      (busy),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_free   (ev_free),
    .clr_base  (clr_base),
    .done      (done),
    .done_fail (done_fail),
    .done_page (done_page)
  );

  window_probe #(.NUM_PAGES(NUM_PAGES), .CW(CW)) u_probe (
    .used     (used),
    .cand     (cand),
    .code     (cur_code),
    .conflict (conflict),
    .beyond   (beyond)
  );

  page_bitmap #(.NUM_PAGES(NUM_PAGES), .RESV_PAGES(RESV_PAGES), .CW(CW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (ev_hit),
    .set_base (cand),
    .set_code (cur_code),
    .clr_en   (ev_free),
    .clr_base (clr_base),
    .clr_code (req_size),
    .used     (used)
  );

endmodule

// File: rtl/page_allocator_chk.sv
module page_allocator_chk
  import pa_pkg::*;
#(
  parameter int NUM_PAGES  = 128,
  parameter int RESV_PAGES = 4,
  parameter int PW         = 7,
  parameter int CW         = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 done_fail,
  input logic [PW-1:0]        done_page,
  input logic [NUM_PAGES-1:0] used,
  input logic [CW-1:0]        cand,
  input logic [1:0]           cur_code,
  input logic                 last_free
);

  logic          grant;
  logic [PW-1:0] last_pg;

  assign grant   = done && !done_fail && !last_free;
  assign last_pg = done_page + PW'(run_len(cur_code) - 1);

  // R9: a search result is reported only once the block is idle again
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a search ends only through a done pulse
  p_busy_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R4: the candidate moves one page per clock while searching
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cand == $past(cand) + CW'(1)));

  // R8: reserved pages are never granted
  p_no_resv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (int'(done_page) >= RESV_PAGES));

  // R5: a granted run lies inside the memory
  p_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (int'(done_page) + run_len(cur_code) <= NUM_PAGES));

  // R6: both ends of a granted run are marked occupied
  p_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (used[done_page] && used[last_pg]));

endmodule

bind page_allocator page_allocator_chk #(
  .NUM_PAGES(NUM_PAGES), .RESV_PAGES(RESV_PAGES), .PW(PW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .done_fail (done_fail),
  .done_page (done_page),
  .used      (used),
  .cand      (cand),
  .cur_code  (cur_code),
  .last_free (last_free)
);

// File: tb/tb_page_allocator.sv
module tb_page_allocator;

  localparam int NP = 32;
  localparam int RV = 4;
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_free = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [PW-1:0] req_start = '0;
  logic          busy, done, done_fail;
  logic [PW-1:0] done_page;

  int n_chk = 0;
  int n_bad = 0;
  bit mdl [NP];
  int lb [64];
  int lc [64];
  int nl = 0;
  logic [15:0] lfsr = 16'hACE1;

  page_allocator #(.NUM_PAGES(NP), .RESV_PAGES(RV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_size(req_size), .req_start(req_start), .busy(busy), .done(done),
    .done_fail(done_fail), .done_page(done_page)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int first_fit(input int len);
    for (int s = 0; s + len <= NP; s++) begin
      bit ok = 1'b1;
      for (int p = s; p < s + len; p++) if (mdl[p]) ok = 1'b0;
      if (ok) return s;
    end
    return -1;
  endfunction

  // Returns granted start or -1; inj >= 0 injects a release of page inj mid-search.
  task automatic do_op(input bit fr, input int code, input int start, input int inj,
                       output int got);
    int len, exp, exp_lat, lat;
    len = 1 << code;
    exp = fr ? start : first_fit(len);
    exp_lat = fr ? 1 : ((exp >= 0) ? exp + 2 : NP - len + 3);
    @(negedge clk);
    chk(done == 1'b0, "R10 idle done", int'(done), 0);
    req_valid = 1'b1; req_free = fr; req_size = 2'(code); req_start = PW'(start);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 1'b0;
        chk(busy == !fr, fr ? "R7 busy low" : "R9 busy high", int'(busy), int'(!fr));
      end
      if (inj >= 0 && lat == 3) begin
        req_valid = 1'b1; req_free = 1'b1; req_size = 2'd0; req_start = PW'(inj);
      end
      if (inj >= 0 && lat == 4) req_valid = 1'b0;
      if (done) break;
      if (lat > 500) begin
        chk(1'b0, "R4 watchdog", lat, exp_lat);
        break;
      end
    end
    chk(lat == exp_lat, fr ? "R7 latency" : "R4 latency", lat, exp_lat);
    if (fr) begin
      chk(done_fail == 1'b0 && int'(done_page) == start, "R7 echo", int'(done_page), start);
      for (int p = start; p < start + len && p < NP; p++) if (p >= RV) mdl[p] = 1'b0;
      got = start;
    end else if (exp < 0) begin
      chk(done_fail == 1'b1, "R5 fail flag", int'(done_fail), 1);
      got = -1;
    end else begin
      chk(done_fail == 1'b0 && int'(done_page) == exp, "R3 first fit", int'(done_page), exp);
      for (int p = exp; p < exp + len; p++) mdl[p] = 1'b1;
      got = exp;
    end
  endtask

  initial begin
    #1500000;
    chk(1'b0, "R4 global watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    for (int p = 0; p < NP; p++) mdl[p] = (p < RV);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);

    // R1/R3: first single page lands just above the reserved area
    do_op(1'b0, 0, 0, -1, g);
    chk(g == RV, "R1 first grant", g, RV);
    // R6: fill every page one at a time, then fail (R5)
    for (int i = 0; i < NP - RV - 1; i++) do_op(1'b0, 0, 0, -1, g);
    do_op(1'b0, 0, 0, -1, g);
    chk(g == -1, "R5 full memory", g, -1);
    // R9: a release injected during a failing search is ignored
    do_op(1'b0, 3, 0, 10, g);
    do_op(1'b0, 0, 0, -1, g);
    chk(g == -1, "R9 injected release ignored", g, -1);
    // R7: single-page hole
    do_op(1'b1, 0, 10, -1, g);
    do_op(1'b0, 1, 0, -1, g);
    chk(g == -1, "R5 two-page no fit", g, -1);
    do_op(1'b0, 0, 0, -1, g);
    chk(g == 10, "R7 exact hole reused", g, 10);
    // R2/R3: eight-page hole split into two four-page runs
    do_op(1'b1, 3, 8, -1, g);
    do_op(1'b0, 2, 0, -1, g);
    do_op(1'b0, 2, 0, -1, g);
    chk(g == 12, "R2 four-page second run", g, 12);
    do_op(1'b0, 0, 0, -1, g);
    // R8: releasing over reserved pages frees only pages 4..7
    do_op(1'b1, 3, 0, -1, g);
    do_op(1'b0, 2, 0, -1, g);
    chk(g == RV, "R8 reserved kept", g, RV);
    // clear all, then unaligned first fit with every size code
    for (int b = 0; b < NP; b += 8) do_op(1'b1, 3, b, -1, g);
    for (int c = 3; c >= 0; c--) do_op(1'b0, c, 0, -1, g);
    for (int b = 0; b < NP; b += 8) do_op(1'b1, 3, b, -1, g);
    // mixed sequence
    nl = 0;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (nl > 0 && (lfsr[2:0] < 3'd3 || nl == 64)) begin
        int idx;
        idx = int'(lfsr[15:8]) % nl;
        do_op(1'b1, lc[idx], lb[idx], -1, g);
        lb[idx] = lb[nl-1]; lc[idx] = lc[nl-1]; nl--;
      end else begin
        int c;
        c = int'(lfsr[5:4]);
        do_op(1'b0, c, 0, -1, g);
        if (g >= 0) begin lb[nl] = g; lc[nl] = c; nl++; end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule